// File: doc/BRIEF.md
# Tiled Surface Address Translator

This block turns the (row, column) position of a texel in a surface into the byte address that texel has in a bank-interleaved tiled memory layout. A tile is 256 bytes wide and 64 lines tall. The block finds which tile the texel falls in and which line of that tile it sits on. It then builds the address from four fields: a row address, a bank, a column selector and a partition bit. Two address bits are scrambled at the end so that accesses spread evenly over the memory channels.

The surface is described by a set of configuration inputs: the tile base address, an address offset, the tile pitch in bytes, the number of tiles per row, an interleave factor, a two-bit bank sense, the bytes per texel and the size of the tile region. The tiles-per-row count and the interleave factor come from outside the block; it does not derive them from the pitch. Requests arrive on a valid/ready handshake. Each result is the 32-bit tiled address plus a flag that says whether the address lies inside the tile region. Only one request is in flight at a time, so results leave in request order. Configuration is captured when a request is accepted, so the inputs may change while a translation is busy.

The tile coordinates need a division by the tiles-per-row count. This is done by a sequential divider, and the request side stalls while the divider runs.

Top module: `tile_addr_xlate`

## Requirements
- R1: `req_ready` is high only when no request is being translated and no result is waiting. A result, once `rsp_valid` is high, holds `rsp_addr` and `rsp_in_bounds` unchanged until a cycle with `rsp_ready` high ends it.
- R2: The linear address is row × pitch + base + offset + column × bytes-per-texel, taken modulo 2^32. Bits [4:0] of the result equal bits [4:0] of the linear address.
- R3: Let t = (linear − base) >> 8 and line = t / tiles_per_row. Then tile x = t mod tiles_per_row, tile y = line >> 6, and line-in-tile = line mod 64. The selector is (tile y × tiles_per_row + tile x + base[31:14]) mod 2^18, and result bits [31:16] equal selector bits [17:2].
- R4: With factor 1, the bank is the selector's low two bits plus the bank sense, modulo 4. The bank is placed in bits [15:14].
- R5: With factor 2, the bank is a lookup at index 4 × ((selector + 2 × tiley[0]) mod 4) + (tile y mod 4), plus the bank sense, modulo 4.
- R6: With factor 4 or more, the bank is a lookup at index 4 × (selector mod 4) + (tile y mod 4), plus the sense. With factor 0 or 3, the lookup value is 0, so the bank equals the sense. The lookup holds 0,1,2,3,2,3,0,1,1,2,3,0,3,0,1,2 for indices 0 to 15.
- R7: The result carries these fields before scrambling:
  - bits [13:11] = line-in-tile[5:3]
  - bits [10:8] = linear[7:5]
  - bit 7 = line-in-tile[2] XOR linear[6]
  - bits [6:5] = line-in-tile[1:0]
- R8: After assembly, bit 9 is inverted when addr[12] ^ bank[0] ^ selector[0] ^ addr[14] is 1. After that, bit 10 is inverted when addr[11] is 1.
- R9: `rsp_in_bounds` is 1 exactly when (result − base) mod 2^32 is less than the region size.
- R10: The configuration inputs are sampled in the cycle a request is accepted. Changes to them while a translation is busy do not alter its result.
- R11: Synchronous reset drops `rsp_valid`, abandons any request in flight and leaves `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | 32 | Tile region base address |
| cfg_offset | input | 32 | Address offset added to the linear address |
| cfg_pitch | input | 16 | Tile pitch in bytes |
| cfg_tiles_per_row | input | 16 | Tiles per row, nonzero |
| cfg_factor | input | 8 | Interleave factor |
| cfg_bank_sense | input | 2 | Bank rotation added to the bank |
| cfg_bpp | input | 4 | Bytes per texel |
| cfg_region_size | input | 32 | Size of the tile region in bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_row | input | 16 | Texel row |
| req_col | input | 16 | Texel column |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed when high together with valid |
| rsp_addr | output | 32 | Tiled address |
| rsp_in_bounds | output | 1 | Address lies inside the tile region |

## Verification
The bench covers every bank path, including factors 0 and 3, which must fall to a lookup value of 0. A decoder that treats them like factor 4 shows up as a wrong bank field. Fixed cases put the line-in-tile on 8 and on 16, which sets bit 11 and then bit 12. A design that applies the two scrambles in the wrong order, or leaves one out, gets bit 9 or bit 10 wrong. The region-size test sits exactly on the boundary, so a less-or-equal compare flips the in-bounds flag. Other tests change the configuration in the middle of a translation, stall the result side, and reset while a request is in flight. These catch a design that reads live configuration, lets a held result drift, or keeps a stale result after reset.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  localparam int ADDR_W     = 32;
  localparam int TILE_SHIFT = 8;            // tile row is 256 bytes
  localparam int LINE_W     = 6;            // 64 lines per tile
  localparam int SEL_W      = 18;
  localparam int SEL_BASE_LSB = 14;
  localparam int TEX_W      = ADDR_W - TILE_SHIFT;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] offset;
    logic [15:0] pitch;
    logic [15:0] tpr;
    logic [7:0]  factor;
    logic [1:0]  sense;
    logic [3:0]  bpp;
    logic [31:0] region;
  } surf_cfg_t;

  // interleave lookup, written out index by index
  function automatic logic [1:0] bank_lut(input logic [3:0] idx);
    case (idx)
      4'd0, 4'd6, 4'd11, 4'd13: return 2'd0;
      4'd1, 4'd7, 4'd8,  4'd14: return 2'd1;
      4'd2, 4'd4, 4'd9,  4'd15: return 2'd2;
      default:                  return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] bank_pick(input logic [SEL_W-1:0] sel,
                                           input logic [1:0] ty_lo,
                                           input logic [7:0] factor,
                                           input logic [1:0] sense);
    logic [1:0] v;
    logic [1:0] rot;
    v = 2'd0;
    rot = sel[1:0] + {ty_lo[0], 1'b0};
    if (factor == 8'd1)      v = sel[1:0];
    else if (factor == 8'd2) v = bank_lut({rot, ty_lo});
    else if (factor >= 8'd4) v = bank_lut({sel[1:0], ty_lo});
    return v + sense;
  endfunction

  function automatic logic [ADDR_W-1:0] build_addr(input logic [SEL_W-1:0] sel,
                                                   input logic [1:0] bank,
                                                   input logic [LINE_W-1:0] lit,
                                                   input logic [ADDR_W-1:0] lin);
    logic [9:0] colsel;
    logic       part;
    logic [ADDR_W-1:0] a;
    colsel = {lit[5:3], lin[7:5], lit[1:0], 2'b00};
    part   = lit[2] ^ lin[6];
    a = {sel[SEL_W-1:2], bank, colsel[9:4], part, colsel[3:2], lin[4:0]};
    a[9]  = a[9] ^ a[12] ^ bank[0] ^ sel[0] ^ a[14];
    a[10] = a[10] ^ a[11];
    return a;
  endfunction
endpackage

// File: rtl/tax_divider.sv
module tax_divider #(
  parameter int DVD_W = 24,
  parameter int DSR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quot,
  output logic [DSR_W-1:0] rem
);
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam int PW    = DVD_W + DSR_W + 1;

  logic [DVD_W-1:0] qr, dvd_q;
  logic [DSR_W-1:0] rr, dsr_q;
  logic [CNT_W-1:0] cnt;
  logic             busy_q, done_q;
  logic [DSR_W:0]   trial;
  logic             fits;

  assign trial = {rr, qr[DVD_W-1]};
  assign fits  = trial >= {1'b0, dsr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      qr <= '0; dvd_q <= '0; rr <= '0; dsr_q <= '0;
      cnt <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        qr <= dividend; dvd_q <= dividend;
        rr <= '0; dsr_q <= divisor;
        cnt <= '0; busy_q <= 1'b1;
      end else if (busy_q) begin
        qr  <= {qr[DVD_W-2:0], fits};
        rr  <= fits ? DSR_W'(trial - {1'b0, dsr_q}) : trial[DSR_W-1:0];
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(DVD_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quot = qr;
  assign rem  = rr;

  // R3
  div_exact_chk: assert property (@(posedge clk) disable iff (rst)
    done && dsr_q != '0 |-> (rr < dsr_q) &&
      (PW'(qr) * PW'(dsr_q) + PW'(rr) == PW'(dvd_q)));

  // R3
  div_done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy_q) && !busy_q);
endmodule

// File: rtl/tile_addr_xlate.sv
module tile_addr_xlate
  import tile_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] cfg_base,
  input  logic [31:0] cfg_offset,
  input  logic [15:0] cfg_pitch,
  input  logic [15:0] cfg_tiles_per_row,
  input  logic [7:0]  cfg_factor,
  input  logic [1:0]  cfg_bank_sense,
  input  logic [3:0]  cfg_bpp,
  input  logic [31:0] cfg_region_size,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_row,
  input  logic [15:0] req_col,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_in_bounds
);
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_DONE} state_t;

  localparam int TY_W = TEX_W - LINE_W;

  state_t      st;
  surf_cfg_t   cfg_c, cfg_q;
  logic [ADDR_W-1:0] lin_c, lin_q, rel_c;
  logic [ADDR_W-1:0] addr_c, addr_q, off_c;
  logic        ib_c, ib_q;

  // named events
  logic accept, deliver, div_done, div_busy;
  logic [TEX_W-1:0] quot;
  logic [15:0]      rem;

  logic [TY_W-1:0]   ty_c;
  logic [LINE_W-1:0] lit_c;
  logic [SEL_W-1:0]  sel_c;
  logic [1:0]        bank_c;

  assign cfg_c = '{base: cfg_base, offset: cfg_offset, pitch: cfg_pitch,
                   tpr: cfg_tiles_per_row, factor: cfg_factor,
                   sense: cfg_bank_sense, bpp: cfg_bpp, region: cfg_region_size};

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_DONE);
  assign accept    = req_valid && req_ready;
  assign deliver   = rsp_valid && rsp_ready;

  assign lin_c = ADDR_W'(req_row) * ADDR_W'(cfg_pitch) + cfg_base + cfg_offset
               + ADDR_W'(req_col) * ADDR_W'(cfg_bpp);
  assign rel_c = lin_c - cfg_base;

  tax_divider #(.DVD_W(TEX_W), .DSR_W(16)) u_div (
    .clk(clk), .rst(rst), .start(accept),
    .dividend(rel_c[ADDR_W-1:TILE_SHIFT]), .divisor(cfg_tiles_per_row),
    .busy(div_busy), .done(div_done), .quot(quot), .rem(rem)
  );

  assign ty_c   = quot[TEX_W-1:LINE_W];
  assign lit_c  = quot[LINE_W-1:0];
  assign sel_c  = SEL_W'(ty_c) * SEL_W'(cfg_q.tpr) + SEL_W'(rem)
                + cfg_q.base[SEL_BASE_LSB +: SEL_W];
  assign bank_c = bank_pick(sel_c, ty_c[1:0], cfg_q.factor, cfg_q.sense);
  assign addr_c = build_addr(sel_c, bank_c, lit_c, lin_q);
  assign off_c  = addr_c - cfg_q.base;
  assign ib_c   = off_c < cfg_q.region;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      cfg_q <= '0; lin_q <= '0; addr_q <= '0; ib_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          cfg_q <= cfg_c;
          lin_q <= lin_c;
          st    <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          addr_q <= addr_c;
          ib_q   <= ib_c;
          st     <= ST_DONE;
        end
        ST_DONE: if (deliver) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rsp_addr      = addr_q;
  assign rsp_in_bounds = ib_q;

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_in_bounds));

  // R1
  one_flight_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready && div_busy);

  // R10
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(cfg_q) && $stable(lin_q));

  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_addr[4:0] == lin_q[4:0]);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid && req_ready);
endmodule

// File: tb/sim_tile_addr_xlate.sv
module sim_tile_addr_xlate;
  typedef struct packed {
    logic [31:0] base;
    logic [31:0] off;
    logic [15:0] pitch;
    logic [15:0] tpr;
    logic [7:0]  factor;
    logic [1:0]  sense;
    logic [3:0]  bpp;
    logic [31:0] region;
    logic [15:0] row;
    logic [15:0] col;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0,        32'h0,    16'h400,  16'd4,  8'd4,  2'd0, 4'd4, 32'hFFFFFFFF, 16'd0,    16'd0},
    '{32'h0,        32'h0,    16'h400,  16'd4,  8'd4,  2'd1, 4'd4, 32'hFFFFFFFF, 16'd37,   16'd100},
    '{32'h0012C000, 32'h100,  16'h300,  16'd3,  8'd1,  2'd0, 4'd2, 32'h01000000, 16'd5,    16'd200},
    '{32'h00034000, 32'h0,    16'h800,  16'd8,  8'd8,  2'd2, 4'd4, 32'h00400000, 16'd130,  16'd511},
    '{32'h0,        32'h40,   16'h500,  16'd5,  8'd1,  2'd3, 4'd2, 32'h10000000, 16'd300,  16'd17},
    '{32'h00100000, 32'h2000, 16'h200,  16'd2,  8'd2,  2'd0, 4'd4, 32'hFFFFFFFF, 16'd65,   16'd63},
    '{32'h00100000, 32'h0,    16'h200,  16'd2,  8'd2,  2'd1, 4'd4, 32'hFFFFFFFF, 16'd200,  16'd127},
    '{32'h00ABC000, 32'h80,   16'h1000, 16'd16, 8'd16, 2'd3, 4'd4, 32'h00010000, 16'd1000, 16'd900},
    '{32'h0,        32'h0,    16'h300,  16'd3,  8'd3,  2'd0, 4'd4, 32'hFFFFFFFF, 16'd70,   16'd30},
    '{32'h0,        32'h0,    16'h100,  16'd1,  8'd0,  2'd2, 4'd1, 32'h00000100, 16'd12,   16'd255},
    '{32'h01000000, 32'h1000, 16'h700,  16'd7,  8'd1,  2'd1, 4'd2, 32'h00800000, 16'd511,  16'd700},
    '{32'h00004000, 32'h0,    16'h400,  16'd4,  8'd2,  2'd2, 4'd4, 32'h00002000, 16'd129,  16'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_base = '0, cfg_offset = '0, cfg_region_size = '0;
  logic [15:0] cfg_pitch = '0, cfg_tiles_per_row = 16'd1;
  logic [7:0]  cfg_factor = '0;
  logic [1:0]  cfg_bank_sense = '0;
  logic [3:0]  cfg_bpp = '0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0;
  logic [15:0] req_row = '0, req_col = '0;
  logic        req_ready, rsp_valid, rsp_in_bounds;
  logic [31:0] rsp_addr;

  int total = 0;
  int failed = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tile_addr_xlate u0 (
    .clk(clk), .rst(rst),
    .cfg_base(cfg_base), .cfg_offset(cfg_offset), .cfg_pitch(cfg_pitch),
    .cfg_tiles_per_row(cfg_tiles_per_row), .cfg_factor(cfg_factor),
    .cfg_bank_sense(cfg_bank_sense), .cfg_bpp(cfg_bpp),
    .cfg_region_size(cfg_region_size),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_in_bounds(rsp_in_bounds)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failed = failed + 1;
      total  = total + 1;
      $display("FAIL watchdog R1: actual hung expected progress");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      failed = failed + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // lookup rows are rotations of 0..3 by 0,2,1,3
  function automatic longint unsigned lut_ref(input longint unsigned idx);
    longint unsigned r = idx / 4;
    longint unsigned sh = (r == 0) ? 0 : (r == 1) ? 2 : (r == 2) ? 1 : 3;
    return ((idx % 4) + sh) % 4;
  endfunction

  function automatic void ref_xlate(input vec_t v, output logic [31:0] a, output logic ib);
    longint unsigned m32 = 64'hFFFF_FFFF;
    longint unsigned lin, tex, line, tx, ty, lit, sel, bk, part, full, b9;
    lin  = (64'(v.row) * 64'(v.pitch) + 64'(v.base) + 64'(v.off)
            + 64'(v.col) * 64'(v.bpp)) & m32;
    tex  = ((lin - 64'(v.base)) & m32) >> 8;
    line = tex / 64'(v.tpr);
    tx   = tex % 64'(v.tpr);
    ty   = line / 64;
    lit  = line % 64;
    sel  = (ty * 64'(v.tpr) + tx + (64'(v.base) >> 14)) % 262144;
    if (v.factor == 1)      bk = sel % 4;
    else if (v.factor == 2) bk = lut_ref(((sel + (ty % 2) * 2) % 4) * 4 + ty % 4);
    else if (v.factor >= 4) bk = lut_ref((sel % 4) * 4 + ty % 4);
    else                    bk = 0;
    bk   = (bk + 64'(v.sense)) % 4;
    part = ((lit >> 2) ^ (lin >> 6)) & 1;
    full = (sel >> 2) * 65536 + bk * 16384
         + (((lit >> 3) & 7) * 8 + ((lin >> 5) & 7)) * 256
         + part * 128 + (lit & 3) * 32 + (lin & 31);
    b9   = ((full >> 12) ^ bk ^ sel ^ (full >> 14)) & 1;
    full = full ^ (b9 << 9);
    full = full ^ (((full >> 11) & 1) << 10);
    a  = full[31:0];
    ib = (((full - 64'(v.base)) & m32) < 64'(v.region));
  endfunction

  task automatic set_cfg(input vec_t v);
    cfg_base = v.base; cfg_offset = v.off; cfg_pitch = v.pitch;
    cfg_tiles_per_row = v.tpr; cfg_factor = v.factor; cfg_bank_sense = v.sense;
    cfg_bpp = v.bpp; cfg_region_size = v.region;
  endtask

  task automatic send(input logic [15:0] r, input logic [15:0] c);
    @(negedge clk);
    req_row = r; req_col = c; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take(output logic [31:0] a, output logic ib);
    while (!rsp_valid) @(negedge clk);
    a = rsp_addr; ib = rsp_in_bounds;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic vec_t mk(input logic [31:0] region, input logic [15:0] pitch,
                              input logic [1:0] sense, input logic [7:0] factor,
                              input logic [15:0] row, input logic [15:0] col);
    vec_t v;
    v = '{base: 32'h0, off: 32'h0, pitch: pitch, tpr: pitch >> 8, factor: factor,
          sense: sense, bpp: 4'd1, region: region, row: row, col: col};
    return v;
  endfunction

  initial begin
    logic [31:0] a, ea, held;
    logic ib, eib;
    logic ok;
    vec_t v;

    // reset state, R11
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 req_ready after reset", {31'b0, req_ready}, 32'd1);

    // vector table, R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i]);
      send(VECS[i].row, VECS[i].col);
      take(a, ib);
      ref_xlate(VECS[i], ea, eib);
      chk($sformatf("R2 R3 R4 R5 R6 R7 R8 addr vector %0d", i), a, ea);
      chk($sformatf("R9 in-bounds vector %0d", i), {31'b0, ib}, {31'b0, eib});
    end

    // R4: origin, factor 1, sense 1 -> bank 1 -> 0x4000
    set_cfg(mk(32'hFFFFFFFF, 16'h100, 2'd1, 8'd1, 16'd0, 16'd0));
    send(16'd0, 16'd0); take(a, ib);
    chk("R4 factor1 sense1 origin", a, 32'h0000_4000);

    // R6: factor 3 ignores the lookup, sense 2 -> 0x8000
    set_cfg(mk(32'hFFFFFFFF, 16'h100, 2'd2, 8'd3, 16'd0, 16'd0));
    send(16'd0, 16'd0); take(a, ib);
    chk("R6 factor3 bank equals sense", a, 32'h0000_8000);

    // R7: column 64 -> linear bit 6 -> bits 9 and 7 -> 0x280
    set_cfg(mk(32'hFFFFFFFF, 16'h100, 2'd0, 8'd1, 16'd0, 16'd64));
    send(16'd0, 16'd64); take(a, ib);
    chk("R7 partition and column", a, 32'h0000_0280);

    // R8: line 16 sets bit 12 -> bit 9 flips -> 0x1200
    set_cfg(mk(32'h0000_1200, 16'h100, 2'd0, 8'd1, 16'd16, 16'd0));
    send(16'd16, 16'd0); take(a, ib);
    chk("R8 bit9 twiddle", a, 32'h0000_1200);
    chk("R9 offset equal to region is out", {31'b0, ib}, 32'd0);

    cfg_region_size = 32'h0000_1201;
    send(16'd16, 16'd0); take(a, ib);
    chk("R9 offset one below region is in", {31'b0, ib}, 32'd1);

    // R8: line 8 sets bit 11 -> bit 10 flips -> 0xC00
    set_cfg(mk(32'hFFFFFFFF, 16'h100, 2'd0, 8'd1, 16'd8, 16'd0));
    send(16'd8, 16'd0); take(a, ib);
    chk("R8 bit10 twiddle", a, 32'h0000_0C00);

    // R10: change configuration while busy
    set_cfg(VECS[3]);
    send(VECS[3].row, VECS[3].col);
    set_cfg(VECS[7]);
    take(a, ib);
    ref_xlate(VECS[3], ea, eib);
    chk("R10 config frozen during translation", a, ea);

    // R1: stall the result side
    set_cfg(VECS[1]);
    send(VECS[1].row, VECS[1].col);
    while (!rsp_valid) @(negedge clk);
    held = rsp_addr;
    ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!rsp_valid || req_ready || rsp_addr !== held) ok = 1'b0;
    end
    chk("R1 result held while stalled", {31'b0, ok}, 32'd1);
    take(a, ib);
    ref_xlate(VECS[1], ea, eib);
    chk("R1 held result value", a, ea);

    // R11: reset in flight
    send(16'd3, 16'd3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ok = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rsp_valid || !req_ready) ok = 1'b0;
    end
    chk("R11 reset abandons request", {31'b0, ok}, 32'd1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule